// File: doc/BRIEF.md
# Inner Loop Issue Controller with Initiation Interval

This block drives a leaf loop whose body is a fixed-latency pipelined datapath. A start pulse loads a loop bound, a step and an initiation interval. The controller then issues body iterations with indices 0, step, 2·step and so on, while each index is below the bound. Consecutive issues are spaced by at least the initiation interval. Each issue is marked by a one-cycle datapath enable, and the iteration index is presented alongside it. A stage-advance enable tells the body's pipeline registers and memory strobes when they may move.

A single-cycle done pulse is raised once the last issued iteration has travelled through the body latency. The controller is then idle and waits for the next start. When the streaming variant is selected, two conditions govern issue. If any write stream is not ready, everything freezes: the interval timer, the loop counter and the in-flight latency tracking all hold their values. An iteration can only issue while every read stream presents valid data.

Top module: `ii_loop_ctrl`

## Requirements
- R1: After reset `busy`, `dp_en`, `done` and `stage_en` are all low.
- R2: `start` is taken only while `busy` is low. The bound, step and interval are captured at that moment and held for the whole run. A `start` raised while `busy` is high changes nothing.
- R3: The iteration indices are 0, s, 2s, … for every value strictly below the bound, using the full arithmetic value with no wrap at the counter width. A step of 0 is taken as 1. The trip count is ceil(bound/s). A bound of 0 issues nothing and raises `done` in the first cycle after `start`.
- R4: The first iteration may issue in the cycle after `start` is taken. Each later issue needs at least II non-stalled cycles since the previous one, counting the cycle of that previous issue. An interval of 0 is taken as 1.
- R5: `dp_en` is high for exactly one cycle per iteration, and `iter_idx` carries that iteration's index in the same cycle. `stage_en` is high whenever `busy` is high and no write stream stalls.
- R6: `done` is a one-cycle pulse. It comes LAT non-stalled cycles after the cycle of the final issue. `busy` is high through the `done` cycle and low in the cycle after it.
- R7: In streaming form, a low bit in `wr_ready` stalls the controller. During a stall there is no issue, no `done`, `stage_en` is low, and the interval timer, the counter and the latency tracking do not advance.
- R8: In streaming form, an iteration issues only when every bit of `rd_valid` is high. Waiting for valid is not a stall, so the interval timer keeps counting.
- R9: With an interval of 1 and no stalls, N iterations issue in cycles 1..N after the `start` cycle, and `done` comes in cycle N+LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| bound_i | input | CNT_W | Loop bound (exclusive) |
| step_i | input | CNT_W | Index increment, 0 taken as 1 |
| ii_i | input | II_W | Initiation interval, 0 taken as 1 |
| rd_valid | input | N_RD | Valid of each read stream |
| wr_ready | input | N_WR | Ready of each write stream |
| busy | output | 1 | Run in progress |
| dp_en | output | 1 | Datapath enable: one pulse per issued iteration |
| iter_idx | output | CNT_W | Index of the issuing iteration |
| stage_en | output | 1 | Body pipeline advance enable |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The bench sweeps every combination of bound, step and interval in a small configuration. The sweep includes zero bounds, zero steps and zero intervals, which would hang or misbehave in a controller that takes them literally. Each run is repeated under pseudo-random write stalls and read-valid gaps. If a controller lets its timer run through a stall, issues come early. If it freezes the timer while waiting for valid, issues come late. If it forgets to freeze the latency tracking, `done` arrives before the last iteration has drained. Stray `start` pulses in the middle of a run would corrupt the trip count in a design that reloads while busy. A bound near the top of the counter range catches an index comparison that wraps and loops forever.

// File: rtl/ii_loop_ctrl.sv
module ii_loop_ctrl #(
  parameter int CNT_W  = 8,
  parameter int II_W   = 4,
  parameter int LAT    = 4,
  parameter int STREAM = 1,
  parameter int N_RD   = 2,
  parameter int N_WR   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bound_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [N_RD-1:0]  rd_valid,
  input  logic [N_WR-1:0]  wr_ready,
  output logic             busy,
  output logic             dp_en,
  output logic [CNT_W-1:0] iter_idx,
  output logic             stage_en,
  output logic             done
);

  localparam logic [LAT-1:0] TOP = LAT'(1) << (LAT - 1);

  logic             run_q, fin_q;
  logic [CNT_W-1:0] cnt_q, bound_q, step_q;
  logic [II_W-1:0]  ii_q, tmr_q;
  logic [LAT-1:0]   pipe_q;
  logic             stall, rd_ok, issue, load;
  logic [CNT_W:0]   next_sum;

  generate
    if (STREAM != 0) begin : g_stream
      assign stall = ~&wr_ready;
      assign rd_ok = &rd_valid;
    end else begin : g_plain
      assign stall = 1'b0;
      assign rd_ok = 1'b1;
    end
  endgenerate

  assign load     = start && !run_q;
  assign issue    = run_q && !fin_q && (tmr_q == '0) && !stall && rd_ok;
  assign next_sum = {1'b0, cnt_q} + {1'b0, step_q};
  assign done     = run_q && fin_q && !stall && (pipe_q == TOP || pipe_q == '0);

  assign busy     = run_q;
  assign dp_en    = issue;
  assign iter_idx = cnt_q;
  assign stage_en = run_q && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
      cnt_q   <= '0;
      bound_q <= '0;
      step_q  <= '0;
      ii_q    <= '0;
      tmr_q   <= '0;
      pipe_q  <= '0;
    end else if (load) begin
      run_q   <= 1'b1;
      fin_q   <= (bound_i == '0);
      cnt_q   <= '0;
      bound_q <= bound_i;
      step_q  <= (step_i == '0) ? CNT_W'(1) : step_i;
      ii_q    <= (ii_i == '0) ? II_W'(1) : ii_i;
      tmr_q   <= '0;
      pipe_q  <= '0;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      if (!stall) pipe_q <= (pipe_q << 1) | LAT'(issue);
      if (issue) begin
        cnt_q <= next_sum[CNT_W-1:0];
        fin_q <= (next_sum >= {1'b0, bound_q});
        tmr_q <= ii_q - II_W'(1);
      end else if (!stall && tmr_q != '0) begin
        tmr_q <= tmr_q - II_W'(1);
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stall) |=> $stable(cnt_q) && $stable(pipe_q) && $stable(tmr_q));

  // R4
  ii_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_en && ii_q != II_W'(1)) |=> !dp_en);

  // R2
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> $stable(bound_q) && $stable(step_q) && $stable(ii_q));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_en |=> iter_idx == $past(iter_idx) + step_q);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !busy && !dp_en && !done);

endmodule

// File: tb/tb_ii_loop_ctrl.sv
module tb_ii_loop_ctrl;
  localparam int CNT_W = 6, II_W = 3, LAT = 3, N_RD = 2, N_WR = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] bound_i = '0, step_i = '0, iter_idx;
  logic [II_W-1:0] ii_i = '0;
  logic [N_RD-1:0] rd_valid = '1;
  logic [N_WR-1:0] wr_ready = '1;
  logic busy, dp_en, stage_en, done;

  int vectors = 0, errors = 0, cyc = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #2 clk = ~clk;

  ii_loop_ctrl #(.CNT_W(CNT_W), .II_W(II_W), .LAT(LAT), .STREAM(1),
                 .N_RD(N_RD), .N_WR(N_WR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bound_i(bound_i),
    .step_i(step_i), .ii_i(ii_i), .rd_valid(rd_valid), .wr_ready(wr_ready),
    .busy(busy), .dp_en(dp_en), .iter_idx(iter_idx), .stage_en(stage_en),
    .done(done));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic run(input int bnd, input int stp, input int ii, input bit noisy);
    int se, ie, n, k, gap, d, c, tgt;
    bit st, vl, ei, ed;
    se = (stp == 0) ? 1 : stp;
    ie = (ii == 0) ? 1 : ii;
    n = (bnd + se - 1) / se;
    tgt = (n == 0) ? 0 : LAT - 1;
    k = 0; gap = 1000; d = 0;
    @(posedge clk); #0.5;
    start = 1'b1; bound_i = CNT_W'(bnd); step_i = CNT_W'(stp); ii_i = II_W'(ii);
    rd_valid = '1; wr_ready = '1;
    @(posedge clk); #0.5;
    start = 1'b0; bound_i = '1; step_i = '0; ii_i = '0;
    for (c = 1; c < 400; c++) begin
      if (noisy) begin
        wr_ready = (rnd() % 4 == 0) ? 2'b10 : 2'b11;
        rd_valid = (rnd() % 4 == 0) ? 2'b01 : 2'b11;
        start = (c == 2);
        bound_i = 6'd1; step_i = 6'd1; ii_i = 3'd1;
      end
      st = (wr_ready != '1);
      vl = (rd_valid == '1);
      ei = !st && vl && gap >= ie && k < n;
      ed = !st && k == n && d == tgt;
      @(negedge clk);
      // R4 R7 R8: issue timing
      chk(dp_en == ei, "R4/R7/R8 dp_en", dp_en, ei);
      // R6 R3: completion
      chk(done == ed, "R6/R3 done", done, ed);
      // R5: stage enable
      chk(stage_en == !st, "R5 stage_en", stage_en, !st);
      // R2: stray start ignored, still busy
      chk(busy == 1'b1, "R2 busy", busy, 1);
      if (ei)
        chk(iter_idx == CNT_W'(k * se), "R3/R5 iter_idx", iter_idx, k * se);
      if (!st) begin
        if (k == n) d++;
        if (ei) begin k++; gap = 1; end else gap++;
      end
      if (ed) break;
      @(posedge clk); #0.5;
    end
    chk(ed, "R6 done reached", ed, 1);
    @(posedge clk); #0.5;
    start = 1'b0; rd_valid = '1; wr_ready = '1;
    @(negedge clk);
    chk(!busy && !done && !dp_en, "R6 idle after done", busy, 0);
  endtask

  task automatic run_ii1(input int nn);
    int c, issues, done_at;
    issues = 0; done_at = -1;
    @(posedge clk); #0.5;
    start = 1'b1; bound_i = CNT_W'(nn); step_i = 6'd1; ii_i = 3'd1;
    rd_valid = '1; wr_ready = '1;
    @(posedge clk); #0.5; start = 1'b0;
    for (c = 1; c < 100; c++) begin
      @(negedge clk);
      if (dp_en) begin
        issues++;
        // R9
        chk(c == issues, "R9 issue cycle", c, issues);
      end
      if (done) begin done_at = c; break; end
      @(posedge clk); #0.5;
    end
    // R9
    chk(issues == nn && done_at == nn + LAT, "R9 done cycle", done_at, nn + LAT);
    @(posedge clk); #0.5;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    start = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !dp_en && !done && !stage_en, "R1 reset idle", busy, 0);
    @(posedge clk); #0.5;
    start = 1'b0; rst_n = 1'b1;
    for (int nz = 0; nz < 2; nz++)
      for (int ii = 0; ii < 6; ii++)
        for (int b = 0; b < 10; b++)
          for (int s = 0; s < 4; s++)
            run(b, s, ii, nz[0]);
    // R3: bound near counter top, sum exceeds width
    run(63, 40, 1, 1'b0);
    run(63, 63, 2, 1'b1);
    run(62, 31, 7, 1'b1);
    for (int nn = 1; nn < 12; nn++) run_ii1(nn);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule